// File: doc/BRIEF.md
# DMA Stream Enable and Item Counter

This block is the control core of a single DMA stream. It holds the stream's run bit, a circular-mode bit and two interrupt-enable bits. It keeps a 16-bit counter of the data items still to move, plus a shadow copy of the last programmed count. The counter gates the peripheral's transfer requests and counts down once for each completed transfer. The stream stops itself when the count runs out in normal mode, when a bus error arrives, or when a FIFO-threshold/burst-size mismatch is reported. In circular mode the stream reloads the count and keeps running.

Software uses a small register port with a write strobe, a 2-bit address, 16 bits of write data and 32 bits of combinational read data. While the stream runs, the configuration is locked, and an enable write is refused while any event flag is still pending. Error conditions arrive as single-cycle input pulses. Each error flag drives its own interrupt output, gated by its enable bit.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After reset, every register reads zero and the grant and both interrupt outputs are low.
- R2: A write to address 1 while stopped loads the item count and its shadow. Reading address 1 returns the count in bits 15:0, and bits 31:16 read as zero.
- R3: While the stream runs, writes to address 1 and to the circular bit (address 0, bit 1) have no effect.
- R4: The grant output equals the request input ANDed with the run bit (address 0, bit 0) and a nonzero count. A transfer-done pulse with a zero count changes nothing.
- R5: Each transfer-done pulse while running with a nonzero count lowers the count by one.
- R6: In normal mode the last transfer leaves the count at zero, clears the run bit and sets the done flag (address 2, bit 0).
- R7: In circular mode the last transfer reloads the count from the shadow, keeps the run bit set and sets the done flag.
- R8: An accepted write of 1 to the run bit while stopped loads the count from the shadow.
- R9: A write of 1 to the run bit is rejected while any flag at address 2 is set. Writing 1 to a flag bit at address 2 clears that flag.
- R10: A bus-error pulse clears the run bit and sets flag bit 1. A FIFO-error pulse clears the run bit and sets flag bit 2. The count holds in both cases.
- R11: When an error and a transfer-done pulse arrive in the same cycle, the error wins: the stream stops, the error flag sets, and the count neither decrements nor reloads.
- R12: The bus-error interrupt equals flag bit 1 ANDed with enable bit 2 of address 0. The FIFO-error interrupt equals flag bit 2 ANDed with enable bit 3. Both enable bits can be written at any time.
- R13: Writing 0 to the run bit stops the stream and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 count, 2 flags |
| regWrData | input | 16 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| reqIn | input | 1 | Transfer request from the peripheral |
| reqGrant | output | 1 | Request passed on to the transfer engine |
| xferDone | input | 1 | One data item transferred (pulse) |
| busErr | input | 1 | Bus transfer error (pulse) |
| fifoErr | input | 1 | FIFO threshold / burst size mismatch (pulse) |
| irqBusErr | output | 1 | Bus-error interrupt |
| irqFifoErr | output | 1 | FIFO-error interrupt |

## Verification
Assertions check the following on every cycle:
- the count-update strobes never overlap;
- a decrement lands exactly one below the previous count and never starts from zero;
- a reload copies the shadow;
- the count stays still while running without a done pulse;
- any error stops the stream on the next cycle;
- an enable write is refused while flags are pending;
- a normal-mode final transfer stops the stream with the done flag set.

Only the bench scenarios show the rest: the full countdown and wrap sequences across many starting counts in both modes, the reload values seen after re-enable, the gated interrupt levels, and what software reads back.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd2;

  // control register bit positions
  localparam int CTRL_RUN    = 0;
  localparam int CTRL_CIRC   = 1;
  localparam int CTRL_BUSIE  = 2;
  localparam int CTRL_FIFOIE = 3;
  localparam int CTRL_W      = 4;

  // flag register bit positions
  localparam int FLAG_DONE   = 0;
  localparam int FLAG_BUSERR = 1;
  localparam int FLAG_FIFO   = 2;
  localparam int FLAG_W      = 3;

  typedef struct packed {
    logic wrShadow;   // software load of count and shadow
    logic reloadCnt;  // count <= shadow
    logic decCnt;     // count <= count - 1
  } cntStrobe_t;

endpackage

// File: rtl/dma_stream_cnt.sv
module dma_stream_cnt
  import dma_stream_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntZero,
  output logic             cntOne
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] shadowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      shadowQ <= '0;
    end else if (strobe.wrShadow) begin
      cntQ    <= wrData;
      shadowQ <= wrData;
    end else if (strobe.reloadCnt) begin
      cntQ    <= shadowQ;
    end else if (strobe.decCnt) begin
      cntQ    <= cntQ - ONE;
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntOne  = (cntQ == ONE);

  // R5: a decrement step lands exactly one below the previous count
  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |=> (cntQ == $past(cntQ) - ONE));

  // R4: the control never asks to decrement an empty count
  p_no_dec_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |-> !cntZero);

  // R7 / R8: a reload copies the programmed shadow
  p_reload_shadow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadCnt |=> (cntQ == $past(shadowQ)));

endmodule

// File: rtl/dma_stream_fsm.sv
module dma_stream_fsm
  import dma_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic              xferDone,
  input  logic              busErr,
  input  logic              fifoErr,
  input  logic              cntZero,
  input  logic              cntOne,
  output logic              runQ,
  output logic              circQ,
  output logic              busIeQ,
  output logic              fifoIeQ,
  output logic [FLAG_W-1:0] flagsQ,
  output cntStrobe_t        strobe
);

  logic wrCtrl, wrCount, wrFlags;
  logic anyErr, accepted, lastItem, wrap, enAccept;
  logic runD;
  logic [FLAG_W-1:0] flagsD;

  assign wrCtrl  = regWr && (regAddr == ADDR_CTRL);
  assign wrCount = regWr && (regAddr == ADDR_COUNT);
  assign wrFlags = regWr && (regAddr == ADDR_FLAGS);

  assign anyErr   = busErr | fifoErr;
  assign accepted = runQ & xferDone & !cntZero & !anyErr;
  assign lastItem = accepted & cntOne;
  assign wrap     = lastItem & circQ;
  assign enAccept = wrCtrl & wrBits[CTRL_RUN] & !runQ & (flagsQ == '0);

  always_comb begin
    strobe.wrShadow  = wrCount & !runQ;
    strobe.reloadCnt = wrap | enAccept;
    strobe.decCnt    = accepted & !wrap;
  end

  always_comb begin
    runD = runQ;
    if (anyErr)                    runD = 1'b0;
    else if (lastItem && !circQ)   runD = 1'b0;
    else if (wrCtrl) begin
      if (!wrBits[CTRL_RUN])       runD = 1'b0;
      else if (enAccept)           runD = 1'b1;
    end
  end

  always_comb begin
    flagsD = flagsQ;
    if (wrFlags) flagsD = flagsQ & ~wrBits[FLAG_W-1:0];
    flagsD[FLAG_DONE]   = flagsD[FLAG_DONE]   | lastItem;
    flagsD[FLAG_BUSERR] = flagsD[FLAG_BUSERR] | busErr;
    flagsD[FLAG_FIFO]   = flagsD[FLAG_FIFO]   | fifoErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      circQ   <= 1'b0;
      busIeQ  <= 1'b0;
      fifoIeQ <= 1'b0;
      flagsQ  <= '0;
    end else begin
      runQ   <= runD;
      flagsQ <= flagsD;
      if (wrCtrl) begin
        busIeQ  <= wrBits[CTRL_BUSIE];
        fifoIeQ <= wrBits[CTRL_FIFOIE];
        if (!runQ) circQ <= wrBits[CTRL_CIRC];
      end
    end
  end

  // R5: at most one count update per cycle
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrShadow, strobe.reloadCnt, strobe.decCnt}));

  // R10: an error pulse always leaves the stream stopped
  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> !runQ);

  // R9: pending flags keep an enable write from starting the stream
  p_flag_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !runQ && (flagsQ != '0)) |=> !runQ);

  // R6: the last normal-mode item stops the stream and raises done
  p_normal_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastItem && !circQ) |=> (!runQ && flagsQ[FLAG_DONE]));

  // R7: a circular wrap keeps the stream running
  p_circ_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> runQ);

endmodule

// File: rtl/dma_stream_ctrl.sv
module dma_stream_ctrl
  import dma_stream_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqIn,
  output logic              reqGrant,
  input  logic              xferDone,
  input  logic              busErr,
  input  logic              fifoErr,
  output logic              irqBusErr,
  output logic              irqFifoErr
);

  cntStrobe_t        strobe;
  logic [CNT_W-1:0]  cntQ;
  logic              cntZero, cntOne;
  logic              runQ, circQ, busIeQ, fifoIeQ;
  logic [FLAG_W-1:0] flagsQ;

  dma_stream_fsm uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .wrBits   (regWrData[CTRL_W-1:0]),
    .xferDone (xferDone),
    .busErr   (busErr),
    .fifoErr  (fifoErr),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .runQ     (runQ),
    .circQ    (circQ),
    .busIeQ   (busIeQ),
    .fifoIeQ  (fifoIeQ),
    .flagsQ   (flagsQ),
    .strobe   (strobe)
  );

  dma_stream_cnt #(.CNT_W(CNT_W)) uCnt (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .cntQ    (cntQ),
    .cntZero (cntZero),
    .cntOne  (cntOne)
  );

  assign reqGrant   = reqIn & runQ & !cntZero;
  assign irqBusErr  = flagsQ[FLAG_BUSERR] & busIeQ;
  assign irqFifoErr = flagsQ[FLAG_FIFO] & fifoIeQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:  regRdData[CTRL_W-1:0] = {fifoIeQ, busIeQ, circQ, runQ};
      ADDR_COUNT: regRdData[CNT_W-1:0]  = cntQ;
      ADDR_FLAGS: regRdData[FLAG_W-1:0] = flagsQ;
      default:    regRdData = '0;
    endcase
  end

  // R3: a running stream without a done pulse keeps its count still
  p_run_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !xferDone) |=> $stable(cntQ));

endmodule

// File: tb/tb_dma_stream_ctrl.sv
module tb_dma_stream_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqIn = 1'b0;
  logic        reqGrant;
  logic        xferDone = 1'b0;
  logic        busErr = 1'b0;
  logic        fifoErr = 1'b0;
  logic        irqBusErr, irqFifoErr;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stream_ctrl dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqIn(reqIn),
    .reqGrant(reqGrant), .xferDone(xferDone), .busErr(busErr),
    .fifoErr(fifoErr), .irqBusErr(irqBusErr), .irqFifoErr(irqFifoErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic pulse(input logic d, input logic b, input logic f);
    @(negedge clk);
    xferDone = d; busErr = b; fifoErr = f;
    @(negedge clk);
    xferDone = 1'b0; busErr = 1'b0; fifoErr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 flags", v, 0);
    reqIn = 1'b1; #1;
    chk("R1 grant", {31'b0, reqGrant}, 0);
    chk("R1 irqs", {30'b0, irqBusErr, irqFifoErr}, 0);

    // R2 count load and readback
    wr(2'd1, 16'hABCD); rd(2'd1, v); chk("R2 count", v, 32'h0000ABCD);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R2 max count", v, 32'h0000FFFF);

    // R4 zero count blocks
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0001);
    rd(2'd0, v); chk("R4 run with zero", v, 1);
    #1 chk("R4 grant blocked", {31'b0, reqGrant}, 0);
    pulse(1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R4 zero holds", v, 0);
    rd(2'd2, v); chk("R4 no flag", v, 0);
    // R13 software stop
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R13 stop", v, 0);

    // sweep both modes over small counts
    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 1; n <= 6; n++) begin
        wr(2'd1, 16'(n));
        wr(2'd0, 16'(1 + 2 * mode));
        rd(2'd0, v); chk("R8 started", v, 32'(1 + 2 * mode));
        #1 chk("R4 grant", {31'b0, reqGrant}, 1);
        // R3 locked writes while running
        wr(2'd1, 16'h0077);
        wr(2'd0, 16'(1 + 2 * (1 - mode)));
        rd(2'd1, v); chk("R3 count locked", v, 32'(n));
        rd(2'd0, v); chk("R3 circ locked", v, 32'(1 + 2 * mode));
        for (int k = 1; k <= (mode == 1 ? n + 2 : n); k++) begin
          int exp;
          pulse(1'b1, 1'b0, 1'b0);
          if (mode == 0) exp = n - k;
          else exp = (k % n == 0) ? n : n - (k % n);
          rd(2'd1, v);
          chk(mode == 0 ? "R5 R6 count" : "R5 R7 count", v, 32'(exp));
        end
        if (mode == 0) begin
          rd(2'd0, v); chk("R6 stopped", v, 0);
          rd(2'd2, v); chk("R6 done flag", v, 1);
          #1 chk("R6 grant off", {31'b0, reqGrant}, 0);
          wr(2'd0, 16'h0001);
          rd(2'd0, v); chk("R9 rejected", v, 0);
          rd(2'd1, v); chk("R9 count kept", v, 0);
          wr(2'd2, 16'h0007);
          rd(2'd2, v); chk("R9 cleared", v, 0);
          wr(2'd0, 16'h0001);
          rd(2'd1, v); chk("R8 reload", v, 32'(n));
          wr(2'd0, 16'h0000);
        end else begin
          rd(2'd0, v); chk("R7 still running", v, 3);
          rd(2'd2, v); chk("R7 done flag", v, 1);
          wr(2'd0, 16'h0000);
          wr(2'd2, 16'h0007);
        end
      end
    end

    // R10 bus error, R12 gating
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0001);
    pulse(1'b0, 1'b1, 1'b0);
    rd(2'd0, v); chk("R10 bus stop", v, 0);
    rd(2'd2, v); chk("R10 bus flag", v, 2);
    rd(2'd1, v); chk("R10 count held", v, 10);
    #1 chk("R12 irq gated", {31'b0, irqBusErr}, 0);
    wr(2'd0, 16'h0004);
    #1 chk("R12 bus irq", {30'b0, irqBusErr, irqFifoErr}, 2);
    wr(2'd2, 16'h0002);
    #1 chk("R12 bus irq cleared", {31'b0, irqBusErr}, 0);

    // R10 fifo error
    wr(2'd0, 16'h0009);
    pulse(1'b0, 1'b0, 1'b1);
    rd(2'd0, v); chk("R10 fifo stop", v, 8);
    rd(2'd2, v); chk("R10 fifo flag", v, 4);
    #1 chk("R12 fifo irq", {30'b0, irqBusErr, irqFifoErr}, 1);
    wr(2'd2, 16'h0004);
    wr(2'd0, 16'h0000);

    // R11 error beats done
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0003);
    pulse(1'b1, 1'b1, 1'b0);
    rd(2'd0, v); chk("R11 stopped", v, 2);
    rd(2'd1, v); chk("R11 count", v, 1);
    rd(2'd2, v); chk("R11 flags", v, 2);
    wr(2'd2, 16'h0007);

    // R13 stop holds count, R8 re-enable reloads
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0001);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R13 stopped", v, 0);
    rd(2'd1, v); chk("R13 count held", v, 3);
    wr(2'd0, 16'h0001);
    rd(2'd1, v); chk("R8 reload after stop", v, 5);
    wr(2'd0, 16'h0000);

    // R5 at the top of the range
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0001);
    pulse(1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R5 max dec", v, 32'h0000FFFE);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule